// File: doc/BRIEF.md
# Event-Driven Up/Down Counter with Run Control

A 16-bit counter for a timer subsystem that advances on a programmable prescaled tick and reacts to a vector of per-cycle event flags. Four event masks decide which event flags act as the count limit, which force the counter into the halted state, which put it into the stopped state and which take it out of the stopped state. In the unidirectional mode a limit returns the count to zero. In the bidirectional mode a limit turns the count around so that it runs down to zero and then climbs again.

Halted and stopped are different idle states. A halted counter ignores all events and only a software write releases it. A stopped counter still watches the event flags and resumes when a start-mask event arrives. A small register port (write strobe, address, write data, combinational read data) holds the control fields, the count and the masks. The count and the direction flag are also driven out directly for neighbouring event logic.

Register addresses: 0 control, 1 count, 2 limit mask, 3 halt mask, 4 stop mask, 5 start mask. Other addresses read as zero. Control fields: bit 0 halt, bit 1 stop, bit 2 clear (write-only), bit 3 bidirectional enable, bit 4 down flag, bits 15:8 prescale value PRE. Event flag n corresponds to bit n of each mask.

Top module: `evc_top`

## Requirements
- R1: While running, the count advances once every PRE+1 clocks. Any write to the control register restarts the prescale phase, so the first advance after a run-enabling write lands PRE+1 clocks after that write.
- R2: With bit 3 = 0, an advance cycle in which an event selected by the limit mask (address 2) is present loads the count with 0. Events not in the limit mask have no effect on the count.
- R3: An up-counting advance from 0xFFFF is treated as a limit even when no limit event is enabled. It gives 0 in the unidirectional mode and 0xFFFE with down flag 1 in the bidirectional mode.
- R4: With bit 3 = 1, a limit while counting up sets the down flag (bit 4, also on down_o) and decrements. A limit while counting down clears the flag and increments. A down count that reaches 0 clears the flag in the same cycle.
- R5: While stopped (bit 1 = 1, halt = 0), the count holds. An event in the start mask (address 5) clears stop, and counting resumes on the following cycle.
- R6: While halted (bit 0 = 1), the count holds and all events are ignored. Halt is set by a halt-mask event (address 3) or by software, and is cleared only by software. Setting halt always clears stop. A write of halt=0, stop=1 leaves the counter stopped.
- R7: When mask actions coincide in one cycle, halt wins over stop and stop wins over start.
- R8: Writing 1 to control bit 2 zeroes the count on that clock edge, taking precedence over an advance. Bit 2 always reads 0.
- R9: Reset leaves the control register at 0x0001 (halted), with count 0. The count register accepts writes only while halted and ignores them otherwise.
- R10: A control write made while not halted changes only the halt and stop bits. PRE, bidirectional enable and down flag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for write and read |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for addr_i (combinational) |
| event_i | input | 16 | Event flags for the current cycle |
| count_o | output | 16 | Current count |
| down_o | output | 1 | Counting-down flag |

## Verification
Plain counting is run with PRE = 0 and PRE = 3. This separates per-clock advance from prescaled advance and confirms where the tick phase starts after a control write. Limit handling is driven three ways: by a masked event, by an unmasked event, and by a preloaded count near 0xFFFF in both modes. This shows that wrap, reversal and the implicit maximum limit are told apart from an ordinary increment. The run-control sequences pulse single and combined mask events while running, stopped and halted. This distinguishes the two idle states from each other and checks the halt/stop/start priority.

// File: rtl/evc_pkg.sv
`timescale 1ns/1ps
package evc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL       = 3'd0,
    REG_COUNT      = 3'd1,
    REG_LIM_MASK   = 3'd2,
    REG_HALT_MASK  = 3'd3,
    REG_STOP_MASK  = 3'd4,
    REG_START_MASK = 3'd5
  } reg_addr_e;

  // control field positions
  localparam int B_HALT  = 0;
  localparam int B_STOP  = 1;
  localparam int B_CLR   = 2;
  localparam int B_BIDIR = 3;
  localparam int B_DOWN  = 4;
  localparam int PRE_LSB = 8;

  // mask slots, in register order starting at REG_LIM_MASK
  localparam int N_MASK  = 4;
  localparam int M_LIM   = 0;
  localparam int M_HALT  = 1;
  localparam int M_STOP  = 2;
  localparam int M_START = 3;
endpackage

// File: rtl/evc_ctrl_regs.sv
`timescale 1ns/1ps
module evc_ctrl_regs
  import evc_pkg::*;
#(
  parameter int EV_W   = 16,
  parameter int PRE_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [EV_W-1:0]              event_i,
  output logic                         halt_o,
  output logic                         stop_o,
  output logic                         run_o,
  output logic                         bidir_o,
  output logic [PRE_W-1:0]             pre_o,
  output logic                         lim_ev_o,
  output logic                         ctrl_we_o,
  output logic                         clr_o,
  output logic                         cnt_we_o,
  output logic                         down_we_o,
  output logic [N_MASK-1:0][EV_W-1:0]  mask_o
);
  logic             halt_q, stop_q, bidir_q;
  logic [PRE_W-1:0] pre_q;
  logic [EV_W-1:0]  mask_q [N_MASK];
  logic [N_MASK-1:0] hit;
  logic             ctrl_we;
  logic             unused_wbits;

  assign unused_wbits = ^wdata_i[PRE_LSB-1:B_DOWN+1];
  assign ctrl_we = wr_en_i && (addr_i == REG_CTRL);

  for (genvar m = 0; m < N_MASK; m++) begin : g_mask
    localparam logic [ADDR_W-1:0] MADDR = ADDR_W'(int'(REG_LIM_MASK) + m);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mask_q[m] <= '0;
      else if (wr_en_i && (addr_i == MADDR))  mask_q[m] <= wdata_i[EV_W-1:0];
    end
    // halted counter evaluates no events
    assign hit[m]    = !halt_q && |(event_i & mask_q[m]);
    assign mask_o[m] = mask_q[m];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q  <= 1'b1;
      stop_q  <= 1'b0;
      bidir_q <= 1'b0;
      pre_q   <= '0;
    end else if (ctrl_we) begin
      halt_q <= wdata_i[B_HALT];
      stop_q <= wdata_i[B_STOP] && !wdata_i[B_HALT];
      if (halt_q) begin
        bidir_q <= wdata_i[B_BIDIR];
        pre_q   <= wdata_i[PRE_LSB +: PRE_W];
      end
    end else if (hit[M_HALT]) begin
      halt_q <= 1'b1;
      stop_q <= 1'b0;
    end else if (hit[M_STOP]) begin
      stop_q <= 1'b1;
    end else if (hit[M_START]) begin
      stop_q <= 1'b0;
    end
  end

  assign halt_o    = halt_q;
  assign stop_o    = stop_q;
  assign run_o     = !halt_q && !stop_q;
  assign bidir_o   = bidir_q;
  assign pre_o     = pre_q;
  assign lim_ev_o  = hit[M_LIM];
  assign ctrl_we_o = ctrl_we;
  assign clr_o     = ctrl_we && wdata_i[B_CLR];
  assign cnt_we_o  = wr_en_i && (addr_i == REG_COUNT) && halt_q;
  assign down_we_o = ctrl_we && halt_q;

  p_halt_clears_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |-> !stop_q);
  p_halt_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !ctrl_we) |=> halt_q);
  p_halt_over_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_we && hit[M_HALT]) |=> (halt_q && !stop_q));
  p_stop_over_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_we && !hit[M_HALT] && hit[M_STOP]) |=> stop_q);
  p_run_fields_guard_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && !halt_q) |=> ($stable(pre_q) && $stable(bidir_q)));
endmodule

// File: rtl/evc_prescaler.sv
`timescale 1ns/1ps
module evc_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pcnt_q;

  assign tick_o = run_i && !restart_i && (pcnt_q == pre_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pcnt_q <= '0;
    else if (restart_i) pcnt_q <= '0;
    else if (run_i)     pcnt_q <= tick_o ? '0 : pcnt_q + PRE_W'(1);
  end

  p_phase_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= pre_i);
  p_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pcnt_q == '0));
endmodule

// File: rtl/evc_count_core.sv
`timescale 1ns/1ps
module evc_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  input  logic             bidir_i,
  input  logic             lim_ev_i,
  input  logic             clr_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             down_we_i,
  input  logic             down_wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic             down_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] count_q, nxt;
  logic             down_q, dn_nxt, at_max, lim;

  assign at_max = (count_q == CNT_MAX);

  always_comb begin
    nxt    = count_q;
    dn_nxt = down_q;
    lim    = lim_ev_i || (!down_q && at_max);
    if (!bidir_i) begin
      nxt    = lim ? '0 : count_q + ONE;
      dn_nxt = 1'b0;
    end else if (!down_q) begin
      if (lim) begin
        if (count_q != '0) begin
          nxt    = count_q - ONE;
          dn_nxt = 1'b1;
        end
      end else begin
        nxt = count_q + ONE;
      end
    end else begin
      if (lim_ev_i || (count_q == '0)) begin
        nxt    = count_q + ONE;
        dn_nxt = 1'b0;
      end else begin
        nxt    = count_q - ONE;
        dn_nxt = (nxt != '0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      down_q  <= 1'b0;
    end else begin
      if (clr_i)          count_q <= '0;
      else if (cnt_we_i)  count_q <= cnt_wdata_i;
      else if (advance_i) count_q <= nxt;
      if (down_we_i)      down_q  <= down_wdata_i;
      else if (advance_i && !clr_i) down_q <= dn_nxt;
    end
  end

  assign count_o = count_q;
  assign down_o  = down_q;

  p_unidir_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !bidir_i && lim_ev_i && !clr_i && !cnt_we_i) |=> (count_q == '0));
  p_max_turn_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && bidir_i && !down_q && at_max && !clr_i && !cnt_we_i && !down_we_i)
    |=> (down_q && count_q == $past(count_q) - ONE));
  p_zero_turn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && bidir_i && down_q && !lim_ev_i && count_q == ONE && !clr_i && !cnt_we_i && !down_we_i)
    |=> (count_q == '0 && !down_q));
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!advance_i && !clr_i && !cnt_we_i) |=> $stable(count_q));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_q == '0));
endmodule

// File: rtl/evc_top.sv
`timescale 1ns/1ps
module evc_top
  import evc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int EV_W   = 16,
  parameter int PRE_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [EV_W-1:0]   event_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              down_o
);
  logic                        halt, stop, run, bidir, lim_ev;
  logic                        ctrl_we, clr, cnt_we, down_we, tick;
  logic [PRE_W-1:0]            pre;
  logic [N_MASK-1:0][EV_W-1:0] mask;

  evc_ctrl_regs #(.EV_W(EV_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .event_i,
    .halt_o(halt), .stop_o(stop), .run_o(run), .bidir_o(bidir), .pre_o(pre),
    .lim_ev_o(lim_ev), .ctrl_we_o(ctrl_we), .clr_o(clr), .cnt_we_o(cnt_we),
    .down_we_o(down_we), .mask_o(mask)
  );

  evc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .run_i(run), .restart_i(ctrl_we), .pre_i(pre), .tick_o(tick)
  );

  evc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .advance_i(tick), .bidir_i(bidir), .lim_ev_i(lim_ev),
    .clr_i(clr), .cnt_we_i(cnt_we), .cnt_wdata_i(wdata_i[CNT_W-1:0]),
    .down_we_i(down_we), .down_wdata_i(wdata_i[B_DOWN]),
    .count_o, .down_o
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: begin
        rdata_o[B_HALT]            = halt;
        rdata_o[B_STOP]            = stop;
        rdata_o[B_BIDIR]           = bidir;
        rdata_o[B_DOWN]            = down_o;
        rdata_o[PRE_LSB +: PRE_W]  = pre;
      end
      REG_COUNT:      rdata_o = DATA_W'(count_o);
      REG_LIM_MASK:   rdata_o = DATA_W'(mask[M_LIM]);
      REG_HALT_MASK:  rdata_o = DATA_W'(mask[M_HALT]);
      REG_STOP_MASK:  rdata_o = DATA_W'(mask[M_STOP]);
      REG_START_MASK: rdata_o = DATA_W'(mask[M_START]);
      default:        rdata_o = '0;
    endcase
  end

  p_count_wr_guard_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_COUNT && !halt && !tick) |=> $stable(count_o));
endmodule

// File: tb/sim_evc_top.sv
`timescale 1ns/1ps
module sim_evc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] ev = '0;
  logic [15:0] count;
  logic        down;
  int          n_vec = 0;
  int          n_bad = 0;
  logic [15:0] d;

  evc_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .event_i(ev), .count_o(count), .down_o(down)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge: exactly one rising edge applies the write
  task automatic wr(input logic [2:0] a, input logic [15:0] v);
    wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic pulse(input logic [15:0] m);
    ev = m;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(3'd0, d);
    check("R9 reset ctrl", d, 16'h0001);
    check("R9 reset count", count, 16'h0000);
    check("R9 reset down", down, 1'b0);
  endtask

  task automatic t_count_write;
    wr(3'd1, 16'h0010);
    rd(3'd1, d);
    check("R9 count write halted", d, 16'h0010);
    wr(3'd0, 16'h0000);
    check("R6 no advance on release edge", count, 16'h0010);
    cyc(5);
    check("R1 pre0 advance", count, 16'h0015);
    wr(3'd1, 16'h5555);
    check("R9 count write while running ignored", count, 16'h0016);
  endtask

  task automatic t_prescale;
    wr(3'd0, 16'h0005);
    wr(3'd0, 16'h0300);
    cyc(3);
    check("R1 pre3 before first tick", count, 16'h0000);
    cyc(1);
    check("R1 pre3 first tick", count, 16'h0001);
    cyc(8);
    check("R1 pre3 after 12 clocks", count, 16'h0003);
  endtask

  task automatic t_limit;
    wr(3'd0, 16'h0005);
    wr(3'd2, 16'h0004);
    wr(3'd0, 16'h0000);
    cyc(5);
    check("R2 count before limit", count, 16'h0005);
    pulse(16'h0008);
    check("R2 unmasked event ignored", count, 16'h0006);
    pulse(16'h0004);
    check("R2 limit wraps to 0", count, 16'h0000);
    cyc(1);
    check("R2 count after wrap", count, 16'h0001);
  endtask

  task automatic t_max;
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'hFFFE);
    wr(3'd0, 16'h0000);
    cyc(1);
    check("R3 reach max", count, 16'hFFFF);
    cyc(1);
    check("R3 unidir max wraps", count, 16'h0000);
  endtask

  task automatic t_bidir;
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'hFFFD);
    wr(3'd0, 16'h0008);
    cyc(3);
    check("R3 bidir max turns count", count, 16'hFFFE);
    check("R4 down flag set at limit", down, 1'b1);
    cyc(1);
    check("R4 counting down", count, 16'hFFFD);
    wr(3'd2, 16'h0004);
    pulse(16'h0004);
    check("R4 limit while down increments", count, 16'hFFFD);
    check("R4 limit while down clears flag", down, 1'b0);
    wr(3'd0, 16'h0009);
    wr(3'd1, 16'h0003);
    wr(3'd0, 16'h0019);
    wr(3'd0, 16'h0018);
    check("R4 down preset", down, 1'b1);
    cyc(3);
    check("R4 reach zero", count, 16'h0000);
    check("R4 flag cleared at zero", down, 1'b0);
    cyc(1);
    check("R4 climbs after zero", count, 16'h0001);
  endtask

  task automatic t_run_ctrl;
    logic [15:0] c;
    wr(3'd0, 16'h0005);
    wr(3'd2, 16'h0000);
    wr(3'd4, 16'h0020);
    wr(3'd5, 16'h0040);
    wr(3'd3, 16'h0080);
    wr(3'd0, 16'h0000);
    cyc(2);
    pulse(16'h0020);
    rd(3'd0, d);
    check("R5 stop event sets stop", d, 16'h0002);
    c = count;
    check("R5 count at stop", c, 16'h0003);
    cyc(3);
    check("R5 stopped holds", count, c);
    pulse(16'h0040);
    check("R5 start edge no advance", count, 16'h0003);
    cyc(1);
    check("R5 resumed", count, 16'h0004);
    pulse(16'h0060);
    rd(3'd0, d);
    check("R7 stop over start", d, 16'h0002);
    cyc(2);
    check("R7 stays stopped", count, 16'h0005);
    pulse(16'h0040);
    cyc(1);
    check("R5 resumed again", count, 16'h0006);
    pulse(16'h00A0);
    rd(3'd0, d);
    check("R7 halt over stop", d, 16'h0001);
    pulse(16'h0040);
    cyc(2);
    rd(3'd0, d);
    check("R6 start ignored when halted", d, 16'h0001);
    check("R6 halted holds", count, 16'h0007);
    wr(3'd0, 16'h0002);
    rd(3'd0, d);
    check("R6 sw halt0 stop1 -> stopped", d, 16'h0002);
    cyc(2);
    check("R6 stopped after sw release", count, 16'h0007);
    pulse(16'h0040);
    cyc(1);
    check("R6 start after sw stop", count, 16'h0008);
    wr(3'd0, 16'h0003);
    rd(3'd0, d);
    check("R6 halt clears stop", d, 16'h0001);
  endtask

  task automatic t_clear;
    wr(3'd0, 16'h0004);
    check("R8 clear while halted", count, 16'h0000);
    wr(3'd0, 16'h0000);
    cyc(4);
    check("R8 running before clear", count, 16'h0004);
    wr(3'd0, 16'h0004);
    check("R8 clear beats advance", count, 16'h0000);
    rd(3'd0, d);
    check("R8 clear bit reads 0", d, 16'h0000);
    cyc(1);
    check("R8 count after clear", count, 16'h0001);
  endtask

  task automatic t_guard;
    logic [15:0] c;
    wr(3'd0, 16'h0508);
    rd(3'd0, d);
    check("R10 running write keeps pre/bidir", d, 16'h0000);
    c = count;
    cyc(1);
    check("R10 pre still 0", count, c + 16'h0001);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_count_write();
    t_prescale();
    t_limit();
    t_max();
    t_bidir();
    t_run_ctrl();
    t_clear();
    t_guard();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule